// File: doc/BRIEF.md
# Floating-Point Subnormal Handling Stage

This stage wraps a single-precision binary floating-point datapath. It handles values whose magnitude is too small for the normal encoding. On the operand side, each of two 32-bit operands is sorted into one of five classes: zero, subnormal, normal, infinity or NaN. Each operand is then unpacked into an explicit 24-bit significand and an effective biased exponent.

A subnormal operand carries an explicit leading zero and is read at the smallest normal exponent, so its effective exponent is 1 and not 0. An optional input mode replaces every subnormal operand with a zero of the same sign before it reaches the arithmetic.

On the result side, the stage takes an unpacked finite result and packs it into a 32-bit word. The result is a signed exponent on the biased scale and a normalised 24-bit significand. A normal result keeps its exponent field. A result below the normal range either loses precision gradually, as a subnormal with a sticky bit for a downstream rounder, or is flushed to a signed zero when the output mode is set.

A small control register holds the two mode bits and two sticky flags. A second view of the same register holds a single bit that sets or clears both modes together. Operand outputs and the packed result are combinational. The flags and modes are registered.

Top module: `fp_subnorm_stage`

## Requirements
- R1: Each operand is classified from its exponent field E and fraction F, with the class code on `op_cls_o`:
  - 0 = zero (E=0, F=0);
  - 1 = subnormal (E=0, F≠0);
  - 2 = normal (0<E<255);
  - 3 = infinity (E=255, F=0);
  - 4 = NaN (E=255, F≠0).
- R2: The unpacked significand is {1,F} when E≠0, {0,F} for a subnormal and 0 for a zero.
- R3: A subnormal operand, when not replaced, has effective exponent 1. A zero has exponent 0. Every other class has exponent E.
- R4: With the input-zero mode set, a subnormal operand reports class 0, exponent 0 and significand 0. Its forwarded word on `op_o` becomes a zero that keeps the operand's sign bit. All other operands are forwarded unchanged.
- R5: With the output-flush mode set, a finite nonzero result with exponent ≤ 0 packs to a zero with the result's sign, and `res_sticky_o` is 0.
- R6: With the output-flush mode clear, a finite result with exponent ≤ 0 packs with exponent field 0. Its fraction is the significand shifted right by (1 − exponent). A shift of 25 or more gives a zero fraction.
- R7: On the subnormal path, `res_sticky_o` is the OR of all significand bits shifted out. On every other path it is 0.
- R8: `res_kind_i` selects 0 = finite, 1 = infinity, 2 or 3 = NaN. Infinity packs as {sign,8'hFF,0}. NaN packs as {sign,8'hFF,significand[22:0]}. Neither depends on the mode bits.
- R9: An input-denormal flag (view 0, bit 0) is set whenever `in_valid_i` is high and any raw operand is subnormal, regardless of the modes. It holds until a write to view 0 with bit 0 set clears it.
- R10: An underflow flag (view 0, bit 1) is set whenever `res_valid_i` is high and the result is flushed, or is packed as a subnormal with the sticky bit set. It holds until a write to view 0 with bit 1 set clears it.
- R11: In view 0 (`csr_sel_i`=0), bit 6 is the input-zero mode and bit 15 is the output-flush mode. Both are written and read back at those positions, and both reset to 0.
- R12: A write to view 1 copies bit 24 into both modes. A read of view 1 returns bit 24 = (input-zero AND output-flush) and 0 elsewhere.
- R13: A finite nonzero result with 1 ≤ exponent ≤ 254 packs as {sign, exponent[7:0], significand[22:0]}. A finite result with exponent ≥ 255 packs as infinity. A zero significand packs as a signed zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operands are live this cycle (gates the input-denormal flag) |
| op_i | input | 2x32 | Raw operand words |
| op_o | output | 2x32 | Operand words after optional subnormal replacement |
| op_cls_o | output | 2x3 | Operand class codes |
| op_exp_o | output | 2x8 | Effective biased exponents |
| op_sig_o | output | 2x24 | Unpacked significands with explicit leading bit |
| res_valid_i | input | 1 | Result is live this cycle (gates the underflow flag) |
| res_kind_i | input | 2 | Result kind: finite, infinity or NaN |
| res_sign_i | input | 1 | Result sign |
| res_exp_i | input | 10 | Signed result exponent on the biased scale |
| res_sig_i | input | 24 | Normalised result significand |
| res_o | output | 32 | Packed result word |
| res_sticky_o | output | 1 | OR of bits lost in subnormal packing |
| csr_we_i | input | 1 | Control register write strobe |
| csr_sel_i | input | 1 | Register view select |
| csr_wdata_i | input | 32 | Control register write data |
| csr_rdata_o | output | 32 | Control register read data for the selected view |

## Verification
A wrong classification or a missed replacement shows at once on the combinational operand outputs. A subnormal with exponent 0, or one leaking through in input-zero mode, is visible in the same cycle as the operand. Mistakes in the shift distance, the sticky bit or the flush path alter `res_o` and `res_sticky_o` in the cycle the result is applied. Row 11 of the result table gives the smallest subnormal, so it exposes an off-by-one shift. A flag that fails to set, fails to hold or clears through the wrong bit appears on the next register read, one edge after the event. A mis-mapped mode bit appears when it is read back through either view.

// File: rtl/fpsn_pkg.sv
package fpsn_pkg;

  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_SUB  = 3'd1,
    FC_NORM = 3'd2,
    FC_INF  = 3'd3,
    FC_NAN  = 3'd4
  } fp_cls_e;

  typedef enum logic [1:0] {
    RK_FINITE = 2'd0,
    RK_INF    = 2'd1,
    RK_NAN    = 2'd2,
    RK_NAN_B  = 2'd3
  } res_kind_e;

endpackage

// File: rtl/fp_operand_unpack.sv
module fp_operand_unpack
  import fpsn_pkg::*;
#(
  parameter int EXPW  = 8,
  parameter int FRACW = 23
) (
  input  logic [EXPW+FRACW:0] op_i,
  input  logic                daz_i,
  output logic [EXPW+FRACW:0] op_o,
  output logic [2:0]          cls_o,
  output logic [EXPW-1:0]     exp_o,
  output logic [FRACW:0]      sig_o,
  output logic                raw_sub_o
);

  localparam int WORDW = EXPW + FRACW + 1;

  logic             sgn;
  logic [EXPW-1:0]  efield;
  logic [FRACW-1:0] frac;
  logic             e_zero;
  logic             e_max;
  logic             f_nz;
  fp_cls_e          cls;

  always_comb begin
    sgn    = op_i[WORDW-1];
    efield = op_i[WORDW-2 -: EXPW];
    frac   = op_i[FRACW-1:0];
    e_zero = (efield == '0);
    e_max  = &efield;
    f_nz   = |frac;

    raw_sub_o = e_zero & f_nz;

    // Default: a plain encoded value with its hidden bit made explicit.
    op_o  = op_i;
    exp_o = efield;
    sig_o = {1'b1, frac};
    cls   = FC_NORM;

    if (e_zero && !f_nz) begin
      cls   = FC_ZERO;
      exp_o = '0;
      sig_o = '0;
    end else if (e_zero) begin
      if (daz_i) begin
        // Input-side replacement keeps only the sign bit.
        cls   = FC_ZERO;
        op_o  = {sgn, {(WORDW-1){1'b0}}};
        exp_o = '0;
        sig_o = '0;
      end else begin
        // Read at the minimum normal exponent, with no hidden bit.
        cls   = FC_SUB;
        exp_o = EXPW'(1);
        sig_o = {1'b0, frac};
      end
    end else if (e_max) begin
      cls = f_nz ? FC_NAN : FC_INF;
    end
  end

  assign cls_o = cls;

endmodule

// File: rtl/fp_result_pack.sv
module fp_result_pack
  import fpsn_pkg::*;
#(
  parameter int EXPW  = 8,
  parameter int FRACW = 23,
  parameter int XEXPW = 10
) (
  input  logic                    ftz_i,
  input  logic [1:0]              kind_i,
  input  logic                    sign_i,
  input  logic signed [XEXPW-1:0] exp_i,
  input  logic [FRACW:0]          sig_i,
  output logic [EXPW+FRACW:0]     word_o,
  output logic                    sticky_o,
  output logic                    flushed_o,
  output logic                    sub_inexact_o
);

  localparam int SIGW  = FRACW + 1;
  localparam int SHMAX = SIGW + 1;
  localparam int SHW   = $clog2(SHMAX + 1);
  localparam int EMAX  = (1 << EXPW) - 1;
  localparam int WIDEW = 2 * SIGW + 1;

  logic signed [XEXPW:0] sh_full;
  logic [SHW-1:0]        amt;
  logic [WIDEW-1:0]      wide;
  logic [FRACW-1:0]      frac_sub;
  logic [SIGW:0]         lost;
  logic                  unused_top_bit;
  res_kind_e             kind;

  // Denormalising shifter: the significand is placed above SIGW+1 guard
  // positions, so even the clamped distance loses nothing off the bottom.
  always_comb begin
    sh_full = (XEXPW+1)'(1) - (XEXPW+1)'(exp_i);
    if (sh_full > SHMAX) amt = SHW'(SHMAX);
    else                 amt = sh_full[SHW-1:0];
    wide     = {sig_i, {(SIGW+1){1'b0}}} >> amt;
    frac_sub = wide[WIDEW-2 -: FRACW];
    lost     = wide[SIGW:0];
  end

  assign unused_top_bit = wide[WIDEW-1];

  always_comb begin
    kind          = res_kind_e'(kind_i);
    word_o        = {sign_i, {(EXPW+FRACW){1'b0}}};
    sticky_o      = 1'b0;
    flushed_o     = 1'b0;
    sub_inexact_o = 1'b0;

    unique case (kind)
      RK_INF: begin
        word_o = {sign_i, {EXPW{1'b1}}, {FRACW{1'b0}}};
      end
      RK_NAN, RK_NAN_B: begin
        word_o = {sign_i, {EXPW{1'b1}}, sig_i[FRACW-1:0]};
      end
      default: begin
        if (sig_i == '0) begin
          word_o = {sign_i, {(EXPW+FRACW){1'b0}}};
        end else if (exp_i >= EMAX) begin
          word_o = {sign_i, {EXPW{1'b1}}, {FRACW{1'b0}}};
        end else if (exp_i >= 1) begin
          word_o = {sign_i, exp_i[EXPW-1:0], sig_i[FRACW-1:0]};
        end else if (ftz_i) begin
          word_o    = {sign_i, {(EXPW+FRACW){1'b0}}};
          flushed_o = 1'b1;
        end else begin
          word_o        = {sign_i, {EXPW{1'b0}}, frac_sub};
          sticky_o      = |lost;
          sub_inexact_o = |lost;
        end
      end
    endcase
  end

endmodule

// File: rtl/fp_mode_csr.sv
module fp_mode_csr #(
  parameter int DATAW    = 32,
  parameter int IDF_BIT  = 0,
  parameter int UF_BIT   = 1,
  parameter int DAZ_BIT  = 6,
  parameter int FTZ_BIT  = 15,
  parameter int BOTH_BIT = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [DATAW-1:0] wdata_i,
  input  logic             set_idf_i,
  input  logic             set_uf_i,
  output logic             daz_o,
  output logic             ftz_o,
  output logic [DATAW-1:0] rdata_o
);

  logic daz_q, ftz_q, idf_q, uf_q;
  logic daz_d, ftz_d, idf_d, uf_d;
  logic clr_idf, clr_uf, reg_en;
  logic unused_wdata;

  always_comb begin
    clr_idf = we_i && !sel_i && wdata_i[IDF_BIT];
    clr_uf  = we_i && !sel_i && wdata_i[UF_BIT];
    daz_d   = daz_q;
    ftz_d   = ftz_q;
    idf_d   = idf_q;
    uf_d    = uf_q;
    if (we_i && !sel_i) begin
      daz_d = wdata_i[DAZ_BIT];
      ftz_d = wdata_i[FTZ_BIT];
    end else if (we_i) begin
      daz_d = wdata_i[BOTH_BIT];
      ftz_d = wdata_i[BOTH_BIT];
    end
    // A new event in the same cycle as a clear wins.
    if (clr_idf)   idf_d = 1'b0;
    if (set_idf_i) idf_d = 1'b1;
    if (clr_uf)    uf_d  = 1'b0;
    if (set_uf_i)  uf_d  = 1'b1;
    reg_en = we_i | set_idf_i | set_uf_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      daz_q <= 1'b0;
      ftz_q <= 1'b0;
      idf_q <= 1'b0;
      uf_q  <= 1'b0;
    end else if (reg_en) begin
      daz_q <= daz_d;
      ftz_q <= ftz_d;
      idf_q <= idf_d;
      uf_q  <= uf_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (!sel_i) begin
      rdata_o[IDF_BIT] = idf_q;
      rdata_o[UF_BIT]  = uf_q;
      rdata_o[DAZ_BIT] = daz_q;
      rdata_o[FTZ_BIT] = ftz_q;
    end else begin
      rdata_o[BOTH_BIT] = daz_q & ftz_q;
    end
  end

  assign daz_o = daz_q;
  assign ftz_o = ftz_q;
  assign unused_wdata = ^wdata_i;

  AST_IDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    idf_q && !clr_idf |=> idf_q);                                  // R9
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q && !clr_uf |=> uf_q);                                     // R10
  AST_IDF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    set_idf_i |=> idf_q);                                          // R9

endmodule

// File: rtl/fp_subnorm_stage.sv
module fp_subnorm_stage
  import fpsn_pkg::*;
#(
  parameter int NOPS  = 2,
  parameter int EXPW  = 8,
  parameter int FRACW = 23,
  parameter int XEXPW = 10,
  parameter int CSRW  = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid_i,
  input  logic [NOPS-1:0][EXPW+FRACW:0]      op_i,
  output logic [NOPS-1:0][EXPW+FRACW:0]      op_o,
  output logic [NOPS-1:0][2:0]               op_cls_o,
  output logic [NOPS-1:0][EXPW-1:0]          op_exp_o,
  output logic [NOPS-1:0][FRACW:0]           op_sig_o,
  input  logic                               res_valid_i,
  input  logic [1:0]                         res_kind_i,
  input  logic                               res_sign_i,
  input  logic signed [XEXPW-1:0]            res_exp_i,
  input  logic [FRACW:0]                     res_sig_i,
  output logic [EXPW+FRACW:0]                res_o,
  output logic                               res_sticky_o,
  input  logic                               csr_we_i,
  input  logic                               csr_sel_i,
  input  logic [CSRW-1:0]                    csr_wdata_i,
  output logic [CSRW-1:0]                    csr_rdata_o
);

  localparam int WORDW = EXPW + FRACW + 1;

  logic            rst_meta_n, rst_sync_n;
  logic            daz, ftz;
  logic [NOPS-1:0] raw_sub;
  logic            flushed, sub_inexact;
  logic            set_idf, set_uf;

  // Reset asserts asynchronously, releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fp_operand_unpack #(.EXPW(EXPW), .FRACW(FRACW)) unpack_i (
      .op_i      (op_i[g]),
      .daz_i     (daz),
      .op_o      (op_o[g]),
      .cls_o     (op_cls_o[g]),
      .exp_o     (op_exp_o[g]),
      .sig_o     (op_sig_o[g]),
      .raw_sub_o (raw_sub[g])
    );

    AST_SUB_EXP_MIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
      op_cls_o[g] == FC_SUB |-> op_exp_o[g] == EXPW'(1) && !op_sig_o[g][FRACW]); // R3
    AST_DAZ_NO_SUB: assert property (@(posedge clk) disable iff (!rst_sync_n)
      daz |-> op_cls_o[g] != FC_SUB);                                            // R4
  end

  fp_result_pack #(.EXPW(EXPW), .FRACW(FRACW), .XEXPW(XEXPW)) pack_i (
    .ftz_i         (ftz),
    .kind_i        (res_kind_i),
    .sign_i        (res_sign_i),
    .exp_i         (res_exp_i),
    .sig_i         (res_sig_i),
    .word_o        (res_o),
    .sticky_o      (res_sticky_o),
    .flushed_o     (flushed),
    .sub_inexact_o (sub_inexact)
  );

  assign set_idf = in_valid_i & (|raw_sub);
  assign set_uf  = res_valid_i & (flushed | sub_inexact);

  fp_mode_csr #(.DATAW(CSRW)) csr_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (csr_we_i),
    .sel_i     (csr_sel_i),
    .wdata_i   (csr_wdata_i),
    .set_idf_i (set_idf),
    .set_uf_i  (set_uf),
    .daz_o     (daz),
    .ftz_o     (ftz),
    .rdata_o   (csr_rdata_o)
  );

  AST_FTZ_NO_SUB_OUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ftz && res_kind_i == RK_FINITE |->
      !(res_o[WORDW-2 -: EXPW] == '0 && res_o[FRACW-1:0] != '0));   // R5
  AST_SPECIAL_EXP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_kind_i != RK_FINITE |-> &res_o[WORDW-2 -: EXPW]);           // R8
  AST_STICKY_SUB_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_sticky_o |-> res_o[WORDW-2 -: EXPW] == '0);                 // R7

endmodule

// File: tb/fp_subnorm_stage_tb_top.sv
module fp_subnorm_stage_tb_top;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0][31:0]  op = '0;
  logic [1:0][31:0]  op_out;
  logic [1:0][2:0]   cls;
  logic [1:0][7:0]   oexp;
  logic [1:0][23:0]  osig;
  logic              res_valid = 1'b0;
  logic [1:0]        rkind = '0;
  logic              rsign = 1'b0;
  logic [9:0]        rexp = '0;
  logic [23:0]       rsig = '0;
  logic [31:0]       res;
  logic              stk;
  logic              we = 1'b0;
  logic              sel = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fp_subnorm_stage dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op),
    .op_o(op_out), .op_cls_o(cls), .op_exp_o(oexp), .op_sig_o(osig),
    .res_valid_i(res_valid), .res_kind_i(rkind), .res_sign_i(rsign),
    .res_exp_i(rexp), .res_sig_i(rsig), .res_o(res), .res_sticky_o(stk),
    .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata), .csr_rdata_o(rdata)
  );

  typedef struct packed {
    logic        daz;
    logic [31:0] op;
    logic [2:0]  cls;
    logic [7:0]  exp;
    logic [23:0] sig;
    logic [31:0] fwd;
  } ovec_t;

  localparam ovec_t OVEC [9] = '{
    '{1'b0, 32'h00000000, 3'd0, 8'd0,   24'h000000, 32'h00000000},
    '{1'b0, 32'h80000000, 3'd0, 8'd0,   24'h000000, 32'h80000000},
    '{1'b0, 32'h00000001, 3'd1, 8'd1,   24'h000001, 32'h00000001},
    '{1'b0, 32'h807FFFFF, 3'd1, 8'd1,   24'h7FFFFF, 32'h807FFFFF},
    '{1'b1, 32'h807FFFFF, 3'd0, 8'd0,   24'h000000, 32'h80000000},
    '{1'b0, 32'h3F800000, 3'd2, 8'd127, 24'h800000, 32'h3F800000},
    '{1'b1, 32'h00800000, 3'd2, 8'd1,   24'h800000, 32'h00800000},
    '{1'b1, 32'h7F800000, 3'd3, 8'd255, 24'h800000, 32'h7F800000},
    '{1'b1, 32'hFFC00001, 3'd4, 8'd255, 24'hC00001, 32'hFFC00001}
  };

  typedef struct packed {
    logic        ftz;
    logic [1:0]  kind;
    logic        sign;
    logic [9:0]  exp;
    logic [23:0] sig;
    logic [31:0] word;
    logic        stk;
  } rvec_t;

  localparam rvec_t RVEC [11] = '{
    '{1'b0, 2'd0, 1'b0, 10'd127,  24'h800000, 32'h3F800000, 1'b0},
    '{1'b0, 2'd0, 1'b0, 10'd1,    24'hFFFFFF, 32'h00FFFFFF, 1'b0},
    '{1'b0, 2'd0, 1'b0, 10'd0,    24'h800000, 32'h00400000, 1'b0},
    '{1'b0, 2'd0, 1'b1, 10'h3FF,  24'h800001, 32'h80200000, 1'b1},
    '{1'b1, 2'd0, 1'b1, 10'h3FF,  24'h800001, 32'h80000000, 1'b0},
    '{1'b1, 2'd0, 1'b0, 10'd0,    24'h800000, 32'h00000000, 1'b0},
    '{1'b0, 2'd0, 1'b0, 10'h3E2,  24'hABCDEF, 32'h00000000, 1'b1},
    '{1'b0, 2'd0, 1'b0, 10'd5,    24'h000000, 32'h00000000, 1'b0},
    '{1'b1, 2'd1, 1'b0, 10'd200,  24'h000000, 32'h7F800000, 1'b0},
    '{1'b1, 2'd2, 1'b1, 10'd3,    24'h400001, 32'hFFC00001, 1'b0},
    '{1'b0, 2'd0, 1'b0, 10'h3EA,  24'h800000, 32'h00000001, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic csr_read(input logic s, output logic [31:0] d);
    @(negedge clk);
    sel = s;
    #1 d = rdata;
  endtask

  task automatic apply_res(input rvec_t v, input logic valid);
    @(negedge clk);
    rkind = v.kind; rsign = v.sign; rexp = v.exp; rsig = v.sig;
    res_valid = valid;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic pulse_op(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op[0] = a; op[1] = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state of both register views.
    csr_read(1'b0, rd); check("R11 reset view0", rd, 32'h0);
    csr_read(1'b1, rd); check("R12 reset view1", rd, 32'h0);

    // Operand table.
    for (int i = 0; i < 9; i++) begin
      csr_write(1'b0, {16'h0, 9'h0, OVEC[i].daz, 6'h0});
      @(negedge clk);
      op[0] = OVEC[i].op; op[1] = 32'h0;
      #1;
      check($sformatf("R1 class row%0d", i), 32'(cls[0]), 32'(OVEC[i].cls));
      check($sformatf("R3 exp row%0d", i), 32'(oexp[0]), 32'(OVEC[i].exp));
      check($sformatf("R2 sig row%0d", i), 32'(osig[0]), 32'(OVEC[i].sig));
      check($sformatf("R4 fwd row%0d", i), op_out[0], OVEC[i].fwd);
    end

    // Result table; each row sets the flush mode first.
    for (int i = 0; i < 11; i++) begin
      csr_write(1'b0, {16'h0, RVEC[i].ftz, 15'h0});
      @(negedge clk);
      rkind = RVEC[i].kind; rsign = RVEC[i].sign;
      rexp = RVEC[i].exp; rsig = RVEC[i].sig;
      #1;
      check($sformatf("R6 R5 R8 R13 word row%0d", i), res, RVEC[i].word);
      check($sformatf("R7 sticky row%0d", i), 32'(stk), 32'(RVEC[i].stk));
    end

    // R11: mode bits read back at their positions.
    csr_write(1'b0, 32'h00008040);
    csr_read(1'b0, rd); check("R11 modes readback", rd, 32'h00008040);
    csr_read(1'b1, rd); check("R12 combined view reads both", rd, 32'h01000000);
    csr_write(1'b1, 32'h0);
    csr_read(1'b0, rd); check("R12 view1 clears both", rd, 32'h0);
    csr_write(1'b1, 32'h01000000);
    csr_read(1'b0, rd); check("R12 view1 sets both", rd, 32'h00008040);

    // R9: input-denormal flag, set, sticky, write-1-clear.
    csr_write(1'b0, 32'h0);
    pulse_op(32'h3F800000, 32'h00000005);
    csr_read(1'b0, rd); check("R9 flag set by subnormal", rd, 32'h1);
    pulse_op(32'h3F800000, 32'h40000000);
    csr_read(1'b0, rd); check("R9 flag sticky", rd, 32'h1);
    csr_write(1'b0, 32'h1);
    csr_read(1'b0, rd); check("R9 flag cleared", rd, 32'h0);
    csr_write(1'b0, 32'h40);
    pulse_op(32'h80000001, 32'h0);
    csr_read(1'b0, rd); check("R9 flag set under input-zero mode", rd, 32'h41);
    csr_write(1'b0, 32'h41);
    csr_read(1'b0, rd); check("R9 clear keeps mode", rd, 32'h40);

    // R10: underflow flag.
    csr_write(1'b0, 32'h0);
    apply_res(RVEC[2], 1'b1);
    csr_read(1'b0, rd); check("R10 exact subnormal no flag", rd, 32'h0);
    apply_res(RVEC[3], 1'b1);
    csr_read(1'b0, rd); check("R10 inexact subnormal sets flag", rd, 32'h2);
    csr_write(1'b0, 32'h2);
    csr_read(1'b0, rd); check("R10 flag cleared", rd, 32'h0);
    csr_write(1'b0, 32'h8000);
    apply_res(RVEC[0], 1'b1);
    csr_read(1'b0, rd); check("R10 normal result no flag", rd, 32'h8000);
    apply_res(RVEC[5], 1'b1);
    csr_read(1'b0, rd); check("R10 flush sets flag", rd, 32'h8002);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule